// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-side engine of a directory coherence scheme serving four caching sites. For every memory block it owns it records a directory state and a sharer bitmask, and it holds the block's data in a small backing store. Caches send it requests (read-shared or exclusive) on one input channel and responses (invalidate acknowledgements, write-backs and flushes) on a second one. Each channel presents the head of a queue: a valid flag, the payload and a "taken" output that pops the entry.

In response it issues grants carrying data to a single site, and probes (invalidate, write-back or flush) addressed to a bitmask of sites. A request that needs other caches to act first triggers the probe, moves the block into one of two transient states, and stays at the head of the request queue. It is served on a later cycle, once the responses have brought the block back to a stable state. Responses are always consumed, so a stalled request can never block the acknowledgement it waits for.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is read-shared with an empty sharer set and holds data zero, and neither grantValid nor probeValid is asserted.
- R2: A read-shared request (reqExcl=0) from a site not in the set of a read-shared block is taken in the cycle it is presented. On the next cycle a grant follows with grantExcl=0, the requester's site and address, and the block's stored data, and the site joins the set.
- R3: A read-shared request from a site already in the set is taken and produces no grant and no probe.
- R4: An exclusive request (reqExcl=1) to a read-shared block whose set is empty or holds only the requester is taken. On the next cycle a grant with grantExcl=1 and the stored data follows, and the requester becomes owner.
- R5: An exclusive request to a read-shared block with other sharers is not taken. On the next cycle it emits an invalidate probe (probeKind=0) whose mask holds every sharer except the requester (mask bit i stands for site i), and the block enters the invalidate-wait state.
- R6: In invalidate-wait, each invalidate acknowledgement (rspKind=0) clears its sender's bit. Once the set is empty the block is read-shared with an empty set, and the stalled exclusive request is granted.
- R7: An invalidate acknowledgement to a read-shared block removes the sender from the sharer set.
- R8: A request from a site other than the owner of an owned block is not taken. On the next cycle it emits a probe to the owner alone: a write-back probe (probeKind=1) for a read-shared request, or a flush probe (probeKind=2) for an exclusive request. The block then enters the data-wait state.
- R9: In the owned or data-wait state, a write-back response (rspKind=1) stores rspData and leaves the sender as the sole sharer. A flush response (rspKind=2) stores rspData and leaves the set empty.
- R10: Any request from the current owner of an owned block is taken with no grant and no probe.
- R11: While a block is in either transient state, requests to it are not taken and produce no output.
- R12: A valid response is always taken. When a request and a response are valid in the same cycle, only the response is processed and the request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request queue head is valid |
| reqExcl | input | 1 | 1 = exclusive request, 0 = read-shared request |
| reqSite | input | 2 | Requesting site |
| reqAddr | input | 2 | Block index of the request |
| reqTaken | output | 1 | Pops the request queue head this cycle |
| rspValid | input | 1 | Response queue head is valid |
| rspKind | input | 2 | 0 invalidate ack, 1 write-back, 2 flush |
| rspSite | input | 2 | Responding site |
| rspAddr | input | 2 | Block index of the response |
| rspData | input | 8 | Data carried by write-back or flush |
| rspTaken | output | 1 | Pops the response queue head this cycle |
| grantValid | output | 1 | Grant issued |
| grantExcl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| grantSite | output | 2 | Destination site of the grant |
| grantAddr | output | 2 | Block index of the grant |
| grantData | output | 8 | Block data sent with the grant |
| probeValid | output | 1 | Probe issued |
| probeKind | output | 2 | 0 invalidate, 1 write-back, 2 flush |
| probeMask | output | 4 | Destination sites, bit i = site i |
| probeAddr | output | 2 | Block index of the probe |

## Verification
The bench drives read-shared requests from new and existing sharers to tell a real grant apart from a silent hit. It sends exclusive requests against an empty set, against a set holding only the requester, and against sets with one or three other sharers, which separates a direct grant from an invalidate round and checks that the probe mask leaves out the requester. Owned blocks receive write-back and flush responses whose data differs from the old contents, so a later grant shows both the stored value and whether the sender stayed a sharer. A collision between a request and a response shows that responses win, and repeated stalled requests show that a transient block issues no second probe.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [1:0] {
    BLK_SHARED    = 2'd0,
    BLK_OWNED     = 2'd1,
    BLK_WAIT_INV  = 2'd2,
    BLK_WAIT_DATA = 2'd3
  } blkState_t;

  localparam logic [1:0] RSP_INV_ACK = 2'd0;
  localparam logic [1:0] RSP_WB      = 2'd1;
  localparam logic [1:0] RSP_FLUSH   = 2'd2;

  localparam logic [1:0] PRB_INV   = 2'd0;
  localparam logic [1:0] PRB_WB    = 2'd1;
  localparam logic [1:0] PRB_FLUSH = 2'd2;

  typedef struct packed {
    logic      wrDir;
    blkState_t nextState;
    logic      wrMem;
    logic      sendGrant;
    logic      grantExcl;
    logic      sendProbe;
    logic [1:0] probeKind;
  } strobe_t;
endpackage

// File: rtl/hdir_ctrl.sv
module hdir_ctrl
  import hdir_pkg::*;
#(
  parameter int NUM_SITES = 4,
  parameter int SITE_W    = 2,
  parameter int ADDR_W    = 2
) (
  input  logic                 reqValid,
  input  logic                 reqExcl,
  input  logic [SITE_W-1:0]    reqSite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 rspValid,
  input  logic [1:0]           rspKind,
  input  logic [SITE_W-1:0]    rspSite,
  input  logic [ADDR_W-1:0]    rspAddr,
  input  blkState_t            curState,
  input  logic [NUM_SITES-1:0] curMask,
  output logic [ADDR_W-1:0]    selAddr,
  output logic [SITE_W-1:0]    selSite,
  output logic                 reqTaken,
  output logic                 rspTaken,
  output strobe_t              strb,
  output logic [NUM_SITES-1:0] nextMask,
  output logic [NUM_SITES-1:0] probeMask
);
  logic [NUM_SITES-1:0] siteBit;
  logic [NUM_SITES-1:0] others;

  // responses take the shared lookup port ahead of requests
  assign selAddr = rspValid ? rspAddr : reqAddr;
  assign selSite = rspValid ? rspSite : reqSite;

  always_comb begin
    siteBit = '0;
    siteBit[selSite] = 1'b1;
  end

  assign others = curMask & ~siteBit;

  always_comb begin
    reqTaken  = 1'b0;
    rspTaken  = 1'b0;
    strb      = '0;
    strb.nextState = BLK_SHARED;
    nextMask  = curMask;
    probeMask = '0;
    if (rspValid) begin
      rspTaken = 1'b1;
      unique case (rspKind)
        RSP_INV_ACK: begin
          if (curState == BLK_SHARED || curState == BLK_WAIT_INV) begin
            strb.wrDir = 1'b1;
            nextMask = curMask & ~siteBit;
            if (curState == BLK_WAIT_INV && nextMask != '0)
              strb.nextState = BLK_WAIT_INV;
            else
              strb.nextState = BLK_SHARED;
          end
        end
        RSP_WB, RSP_FLUSH: begin
          if (curState == BLK_OWNED || curState == BLK_WAIT_DATA) begin
            strb.wrDir = 1'b1;
            strb.wrMem = 1'b1;
            strb.nextState = BLK_SHARED;
            nextMask = (rspKind == RSP_WB) ? siteBit : '0;
          end
        end
        default: ;
      endcase
    end else if (reqValid) begin
      unique case (curState)
        BLK_SHARED: begin
          if (!reqExcl) begin
            reqTaken = 1'b1;
            if ((curMask & siteBit) == '0) begin
              strb.wrDir = 1'b1;
              strb.nextState = BLK_SHARED;
              nextMask = curMask | siteBit;
              strb.sendGrant = 1'b1;
            end
          end else if (others == '0) begin
            reqTaken = 1'b1;
            strb.wrDir = 1'b1;
            strb.nextState = BLK_OWNED;
            nextMask = siteBit;
            strb.sendGrant = 1'b1;
            strb.grantExcl = 1'b1;
          end else begin
            strb.wrDir = 1'b1;
            strb.nextState = BLK_WAIT_INV;
            nextMask = others;
            strb.sendProbe = 1'b1;
            strb.probeKind = PRB_INV;
            probeMask = others;
          end
        end
        BLK_OWNED: begin
          if ((curMask & siteBit) != '0) begin
            reqTaken = 1'b1;
          end else begin
            strb.wrDir = 1'b1;
            strb.nextState = BLK_WAIT_DATA;
            nextMask = curMask;
            strb.sendProbe = 1'b1;
            strb.probeKind = reqExcl ? PRB_FLUSH : PRB_WB;
            probeMask = curMask;
          end
        end
        default: ;  // transient: hold the request at the queue head
      endcase
    end
  end
endmodule

// File: rtl/hdir_datapath.sv
module hdir_datapath
  import hdir_pkg::*;
#(
  parameter int NUM_SITES  = 4,
  parameter int NUM_BLOCKS = 4,
  parameter int SITE_W     = 2,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NUM_SITES-1:0] nextMask,
  input  logic [NUM_SITES-1:0] probeMaskIn,
  input  logic [ADDR_W-1:0]    selAddr,
  input  logic [SITE_W-1:0]    selSite,
  input  logic [DATA_W-1:0]    wrData,
  output blkState_t            curState,
  output logic [NUM_SITES-1:0] curMask,
  output logic                 grantValid,
  output logic                 grantExcl,
  output logic [SITE_W-1:0]    grantSite,
  output logic [ADDR_W-1:0]    grantAddr,
  output logic [DATA_W-1:0]    grantData,
  output logic                 probeValid,
  output logic [1:0]           probeKind,
  output logic [NUM_SITES-1:0] probeMask,
  output logic [ADDR_W-1:0]    probeAddr
);
  blkState_t            dirState [NUM_BLOCKS];
  logic [NUM_SITES-1:0] dirMask  [NUM_BLOCKS];
  logic [DATA_W-1:0]    memData  [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] blkHit;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_hit
    assign blkHit[b] = (selAddr == ADDR_W'(b));
  end

  assign curState = dirState[selAddr];
  assign curMask  = dirMask[selAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        dirState[b] <= BLK_SHARED;
        dirMask[b]  <= '0;
        memData[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        if (blkHit[b] && strb.wrDir) begin
          dirState[b] <= strb.nextState;
          dirMask[b]  <= nextMask;
        end
        if (blkHit[b] && strb.wrMem) memData[b] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantExcl  <= 1'b0;
      grantSite  <= '0;
      grantAddr  <= '0;
      grantData  <= '0;
      probeValid <= 1'b0;
      probeKind  <= '0;
      probeMask  <= '0;
      probeAddr  <= '0;
    end else begin
      grantValid <= strb.sendGrant;
      grantExcl  <= strb.grantExcl;
      grantSite  <= selSite;
      grantAddr  <= selAddr;
      grantData  <= memData[selAddr];
      probeValid <= strb.sendProbe;
      probeKind  <= strb.probeKind;
      probeMask  <= probeMaskIn;
      probeAddr  <= selAddr;
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdir_pkg::*;
#(
  parameter int NUM_SITES  = 4,
  parameter int NUM_BLOCKS = 4,
  parameter int DATA_W     = 8,
  localparam int SITE_W    = $clog2(NUM_SITES),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqExcl,
  input  logic [SITE_W-1:0]    reqSite,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 reqTaken,
  input  logic                 rspValid,
  input  logic [1:0]           rspKind,
  input  logic [SITE_W-1:0]    rspSite,
  input  logic [ADDR_W-1:0]    rspAddr,
  input  logic [DATA_W-1:0]    rspData,
  output logic                 rspTaken,
  output logic                 grantValid,
  output logic                 grantExcl,
  output logic [SITE_W-1:0]    grantSite,
  output logic [ADDR_W-1:0]    grantAddr,
  output logic [DATA_W-1:0]    grantData,
  output logic                 probeValid,
  output logic [1:0]           probeKind,
  output logic [NUM_SITES-1:0] probeMask,
  output logic [ADDR_W-1:0]    probeAddr
);
  strobe_t              strb;
  blkState_t            curState;
  logic [NUM_SITES-1:0] curMask;
  logic [NUM_SITES-1:0] nextMask;
  logic [NUM_SITES-1:0] probeMaskNext;
  logic [ADDR_W-1:0]    selAddr;
  logic [SITE_W-1:0]    selSite;

  hdir_ctrl #(.NUM_SITES(NUM_SITES), .SITE_W(SITE_W), .ADDR_W(ADDR_W)) i_ctrl (
    .reqValid(reqValid), .reqExcl(reqExcl), .reqSite(reqSite), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspKind(rspKind), .rspSite(rspSite), .rspAddr(rspAddr),
    .curState(curState), .curMask(curMask),
    .selAddr(selAddr), .selSite(selSite),
    .reqTaken(reqTaken), .rspTaken(rspTaken),
    .strb(strb), .nextMask(nextMask), .probeMask(probeMaskNext)
  );

  hdir_datapath #(.NUM_SITES(NUM_SITES), .NUM_BLOCKS(NUM_BLOCKS), .SITE_W(SITE_W),
                  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nextMask(nextMask),
    .probeMaskIn(probeMaskNext), .selAddr(selAddr), .selSite(selSite),
    .wrData(rspData), .curState(curState), .curMask(curMask),
    .grantValid(grantValid), .grantExcl(grantExcl), .grantSite(grantSite),
    .grantAddr(grantAddr), .grantData(grantData),
    .probeValid(probeValid), .probeKind(probeKind), .probeMask(probeMask),
    .probeAddr(probeAddr)
  );
endmodule

// File: rtl/hdir_checker.sv
module hdir_checker #(
  parameter int NUM_SITES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqTaken,
  input logic                 rspValid,
  input logic                 grantValid,
  input logic                 probeValid,
  input logic [1:0]           probeKind,
  input logic [NUM_SITES-1:0] probeMask
);
  // R12
  rsp_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqTaken |-> !rspValid);

  // R2
  grant_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(reqTaken));

  // R11
  probe_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |-> $past(reqValid && !reqTaken));

  // R5
  probe_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |-> probeMask != '0);

  // R8
  owner_probe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && probeKind != 2'd0) |-> $countones(probeMask) == 1);

  // R11
  grant_probe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && probeValid));
endmodule

bind home_dir_ctrl hdir_checker #(.NUM_SITES(NUM_SITES)) i_hdir_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTaken(reqTaken),
  .rspValid(rspValid), .grantValid(grantValid), .probeValid(probeValid),
  .probeKind(probeKind), .probeMask(probeMask)
);

// File: tb/test_home_dir_ctrl.sv
`timescale 1ns/1ps
module test_home_dir_ctrl;
  localparam int NS = 4;
  localparam int SW = 2;
  localparam int AW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqExcl = 1'b0;
  logic [SW-1:0] reqSite = '0;
  logic [AW-1:0] reqAddr = '0;
  logic reqTaken;
  logic rspValid = 1'b0;
  logic [1:0] rspKind = '0;
  logic [SW-1:0] rspSite = '0;
  logic [AW-1:0] rspAddr = '0;
  logic [DW-1:0] rspData = '0;
  logic rspTaken;
  logic grantValid, grantExcl;
  logic [SW-1:0] grantSite;
  logic [AW-1:0] grantAddr;
  logic [DW-1:0] grantData;
  logic probeValid;
  logic [1:0] probeKind;
  logic [NS-1:0] probeMask;
  logic [AW-1:0] probeAddr;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  home_dir_ctrl i_home_dir_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqExcl(reqExcl), .reqSite(reqSite), .reqAddr(reqAddr),
    .reqTaken(reqTaken),
    .rspValid(rspValid), .rspKind(rspKind), .rspSite(rspSite), .rspAddr(rspAddr),
    .rspData(rspData), .rspTaken(rspTaken),
    .grantValid(grantValid), .grantExcl(grantExcl), .grantSite(grantSite),
    .grantAddr(grantAddr), .grantData(grantData),
    .probeValid(probeValid), .probeKind(probeKind), .probeMask(probeMask),
    .probeAddr(probeAddr)
  );

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge with outputs settled
  task automatic step(input logic qV, input logic qX, input int qS, input int qA,
                      input logic sV, input int sK, input int sS, input int sA,
                      input int sD, output logic tq, output logic ts);
    reqValid = qV; reqExcl = qX; reqSite = SW'(qS); reqAddr = AW'(qA);
    rspValid = sV; rspKind = 2'(sK); rspSite = SW'(sS); rspAddr = AW'(sA);
    rspData = DW'(sD);
    #1;
    tq = reqTaken;
    ts = rspTaken;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    rspValid = 1'b0;
  endtask

  task automatic req(input string tag, input logic x, input int s, input int a,
                     input int expTaken);
    logic tq, ts;
    step(1'b1, x, s, a, 1'b0, 0, 0, 0, 0, tq, ts);
    chk({tag, " reqTaken"}, int'(tq), expTaken);
  endtask

  task automatic rsp(input string tag, input int k, input int s, input int a,
                     input int d);
    logic tq, ts;
    step(1'b0, 1'b0, 0, 0, 1'b1, k, s, a, d, tq, ts);
    chk({tag, " rspTaken"}, int'(ts), 1);
  endtask

  task automatic expGrant(input string tag, input int x, input int s, input int a,
                          input int d);
    chk({tag, " grantValid"}, int'(grantValid), 1);
    chk({tag, " grantExcl"}, int'(grantExcl), x);
    chk({tag, " grantSite"}, int'(grantSite), s);
    chk({tag, " grantAddr"}, int'(grantAddr), a);
    chk({tag, " grantData"}, int'(grantData), d);
    chk({tag, " probeValid"}, int'(probeValid), 0);
  endtask

  task automatic expProbe(input string tag, input int k, input int m, input int a);
    chk({tag, " probeValid"}, int'(probeValid), 1);
    chk({tag, " probeKind"}, int'(probeKind), k);
    chk({tag, " probeMask"}, int'(probeMask), m);
    chk({tag, " probeAddr"}, int'(probeAddr), a);
    chk({tag, " grantValid"}, int'(grantValid), 0);
  endtask

  task automatic expQuiet(input string tag);
    chk({tag, " grantValid"}, int'(grantValid), 0);
    chk({tag, " probeValid"}, int'(probeValid), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    expQuiet("R1 reset");
    chk("R1 reset reqTaken", int'(reqTaken), 0);
    chk("R1 reset rspTaken", int'(rspTaken), 0);
  endtask

  task automatic t_shared();
    req("R2 first sharer", 1'b0, 1, 0, 1);
    expGrant("R2 first sharer", 0, 1, 0, 0);
    req("R3 repeat sharer", 1'b0, 1, 0, 1);
    expQuiet("R3 repeat sharer");
    req("R2 second sharer", 1'b0, 2, 0, 1);
    expGrant("R2 second sharer", 0, 2, 0, 0);
  endtask

  task automatic t_invalidate();
    req("R5 excl with sharer", 1'b1, 1, 0, 0);
    expProbe("R5 excl with sharer", 0, 4'b0100, 0);
    req("R11 stall in inv wait", 1'b1, 1, 0, 0);
    expQuiet("R11 stall in inv wait");
    rsp("R6 last ack", 0, 2, 0, 0);
    expQuiet("R6 last ack");
    req("R6 served after acks", 1'b1, 1, 0, 1);
    expGrant("R6 served after acks", 1, 1, 0, 0);
  endtask

  task automatic t_writeback();
    req("R10 owner excl again", 1'b1, 1, 0, 1);
    expQuiet("R10 owner excl again");
    req("R8 shared to owned", 1'b0, 3, 0, 0);
    expProbe("R8 shared to owned", 1, 4'b0010, 0);
    req("R11 stall in data wait", 1'b0, 3, 0, 0);
    expQuiet("R11 stall in data wait");
    rsp("R9 wb reply", 1, 1, 0, 8'hA5);
    expQuiet("R9 wb reply");
    req("R9 shared after wb", 1'b0, 3, 0, 1);
    expGrant("R9 shared after wb", 0, 3, 0, 8'hA5);
  endtask

  task automatic t_flush();
    rsp("R7 ack while shared", 0, 3, 0, 0);
    req("R7 excl sole sharer", 1'b1, 1, 0, 1);
    expGrant("R7 R4 excl sole sharer", 1, 1, 0, 8'hA5);
    req("R8 excl to owned", 1'b1, 0, 0, 0);
    expProbe("R8 excl to owned", 2, 4'b0010, 0);
    rsp("R9 flush reply", 2, 1, 0, 8'h3C);
    req("R9 excl after flush", 1'b1, 0, 0, 1);
    expGrant("R9 excl after flush", 1, 0, 0, 8'h3C);
  endtask

  task automatic t_multi_ack();
    for (int s = 0; s < 3; s++) begin
      req("R2 block1 sharer", 1'b0, s, 1, 1);
      expGrant("R2 block1 sharer", 0, s, 1, 0);
    end
    req("R5 three sharers", 1'b1, 3, 1, 0);
    expProbe("R5 three sharers", 0, 4'b0111, 1);
    rsp("R6 first ack", 0, 0, 1, 0);
    req("R6 still waiting", 1'b1, 3, 1, 0);
    expQuiet("R6 still waiting");
    rsp("R6 second ack", 0, 1, 1, 0);
    rsp("R6 third ack", 0, 2, 1, 0);
    req("R6 served block1", 1'b1, 3, 1, 1);
    expGrant("R6 served block1", 1, 3, 1, 0);
  endtask

  task automatic t_priority();
    logic tq, ts;
    step(1'b1, 1'b0, 0, 2, 1'b1, 0, 1, 3, 0, tq, ts);
    chk("R12 collision reqTaken", int'(tq), 0);
    chk("R12 collision rspTaken", int'(ts), 1);
    expQuiet("R12 collision");
    req("R12 request after collision", 1'b0, 0, 2, 1);
    expGrant("R12 request after collision", 0, 0, 2, 0);
    req("R4 excl empty set", 1'b1, 2, 3, 1);
    expGrant("R4 excl empty set", 1, 2, 3, 0);
  endtask

  initial begin
    t_reset();
    t_shared();
    t_invalidate();
    t_writeback();
    t_flush();
    t_multi_ack();
    t_priority();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule